// File: doc/BRIEF.md
# Dual-Channel Shadowed Configuration Register File

This block holds the configuration state behind the serial control port of a two-channel data converter. A front end that has already decoded the serial frames presents one register access per cycle: an address, a write byte with a write strobe, and a read strobe. The block stores the bytes and drives the active configuration to the rest of the device, one copy for channel A and one for channel B.

A run of setup registers is double-buffered. A write changes only a shadow copy. A transfer command then copies every shadow byte into its active copy in a single cycle, so the whole set of changes reaches the device at once. The lower part of that run is per-channel. Each channel has its own copy, and a two-bit channel mask decides which copies a write reaches and which copy a read returns. The upper part is global. It has one copy, and the mask does not affect it.

The access port is a control port with no back-pressure. Every strobe is accepted in the cycle it is presented. A read answers exactly one cycle later with a data byte and a valid pulse. If a read and a write arrive in the same cycle they use the same address, and the read returns the value from before the write.

Top module: `cfg_dual_regfile`

## Requirements
- R1: After reset the channel mask reads 0x03, address 0xFF reads 0x00, and every shadow and active byte at offset k from 0x08 holds 0x40+k, on both channels.
- R2: Address 0x05 holds the channel mask. Bit 0 selects channel A and bit 1 selects channel B. A write keeps only bits 1:0, and a read returns them with bits 7:2 as zero.
- R3: A write to 0x08..0x18 changes only the shadow copies. The active outputs keep their values until a transfer.
- R4: A write to 0xFF with bit 0 set starts a transfer. One clock edge after the write edge, every active byte takes its shadow value, all in the same cycle.
- R5: The transfer bit clears itself after one cycle. A read of 0xFF returns 0x00 unless a transfer write happened in the cycle before.
- R6: A write to a local register (0x08..0x0F) reaches channel A when mask bit 0 is set and channel B when mask bit 1 is set. With mask 0x03 it reaches both, and with mask 0x00 it reaches neither.
- R7: A read of a local register returns channel B only when the mask is 0x02. For masks 0x01, 0x03 and 0x00 it returns channel A.
- R8: Global registers (0x10..0x18) have a single copy. They are written and read the same way for every mask value, and channel B's active output carries the same bytes as channel A's.
- R9: A read of a shadowed register returns its shadow copy, which is the last value written, whether or not a transfer has happened.
- R10: Writes to unmapped addresses change no state, and reads from them return 0x00.
- R11: rd_valid is high exactly in the cycle after an rd_en cycle, and rd_data holds the read result in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | AW (8) | Register address for reads and writes |
| wr_data | input | DW (8) | Write byte |
| rd_data | output | DW (8) | Read result, valid one cycle after rd_en |
| rd_valid | output | 1 | High in the cycle rd_data is valid |
| act_a | output | N_SHD*DW (136) | Channel A active bytes, offset k at bits k*8 and up |
| act_b | output | N_SHD*DW (136) | Channel B active bytes, same layout |

## Verification
The bench drives local writes under each of the four mask values. Only the full mask reaches both copies, only the two single-bit masks reach one copy each, and only the empty mask drops the write. Local reads are done under each mask as well, which separates the channel B read case from the three cases that fall back to channel A. The active outputs are compared against a model after every plain write and in the gap cycle after a transfer write. This separates shadow-only updates from an early or late copy. Seeded random mixes of writes, reads, transfers and unmapped accesses then test whether the global copy ignores the mask and whether unmapped traffic has no effect.

// File: rtl/cfg_regfile_pkg.sv
package cfg_regfile_pkg;

  typedef enum logic [2:0] {
    KIND_NONE    = 3'd0,
    KIND_CHMASK  = 3'd1,
    KIND_XFER    = 3'd2,
    KIND_SHD_LOC = 3'd3,
    KIND_SHD_GLB = 3'd4
  } reg_kind_e;

  // reset value of the shadowed byte at offset off
  function automatic logic [7:0] shd_reset_val(int unsigned off);
    return 8'(32'h40 + off);
  endfunction

endpackage

// File: rtl/cfg_addr_decode.sv
module cfg_addr_decode
  import cfg_regfile_pkg::*;
#(
  parameter int unsigned AW        = 8,
  parameter int unsigned SHD_BASE  = 8,
  parameter int unsigned N_SHD     = 17,
  parameter int unsigned N_LOCAL   = 8,
  parameter int unsigned MASK_ADDR = 5,
  parameter int unsigned XFER_ADDR = 255,
  parameter int unsigned OW        = 5
) (
  input  logic [AW-1:0] addr,
  output reg_kind_e     kind,
  output logic [OW-1:0] off
);
  localparam logic [AW-1:0] BASE_A = AW'(SHD_BASE);
  localparam logic [AW-1:0] LAST_A = AW'(SHD_BASE + N_SHD - 1);
  localparam logic [AW-1:0] LOC_LAST_A = AW'(SHD_BASE + N_LOCAL - 1);

  logic [AW-1:0] diff;

  always_comb begin
    diff = addr - BASE_A;
    off  = diff[OW-1:0];
    if (addr == AW'(MASK_ADDR))
      kind = KIND_CHMASK;
    else if (addr == AW'(XFER_ADDR))
      kind = KIND_XFER;
    else if (addr >= BASE_A && addr <= LOC_LAST_A)
      kind = KIND_SHD_LOC;
    else if (addr > LOC_LAST_A && addr <= LAST_A)
      kind = KIND_SHD_GLB;
    else
      kind = KIND_NONE;
  end
endmodule

// File: rtl/cfg_shadow_bank.sv
module cfg_shadow_bank
  import cfg_regfile_pkg::*;
#(
  parameter int unsigned N_REG = 17,
  parameter int unsigned DW    = 8,
  parameter int unsigned OW    = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [OW-1:0]     wr_off,
  input  logic [DW-1:0]     wr_data,
  input  logic              xfer,
  output logic [N_REG*DW-1:0] shd_flat,
  output logic [N_REG*DW-1:0] act_flat
);
  for (genvar i = 0; i < N_REG; i++) begin : g_reg
    localparam logic [DW-1:0] RST_V = DW'(shd_reset_val(i));
    logic [DW-1:0] shd_q;
    logic [DW-1:0] act_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        shd_q <= RST_V;
      else if (wr_en && wr_off == OW'(i))
        shd_q <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        act_q <= RST_V;
      else if (xfer)
        act_q <= shd_q;
    end

    assign shd_flat[i*DW +: DW] = shd_q;
    assign act_flat[i*DW +: DW] = act_q;
  end
endmodule

// File: rtl/cfg_read_mux.sv
module cfg_read_mux
  import cfg_regfile_pkg::*;
#(
  parameter int unsigned DW      = 8,
  parameter int unsigned N_SHD   = 17,
  parameter int unsigned N_LOCAL = 8,
  parameter int unsigned OW      = 5
) (
  input  reg_kind_e             kind,
  input  logic [OW-1:0]         off,
  input  logic [1:0]            chmask,
  input  logic                  xfer_q,
  input  logic [N_SHD*DW-1:0]   shd_a,
  input  logic [N_LOCAL*DW-1:0] shd_b,
  output logic [DW-1:0]         rd_val
);
  logic [DW-1:0] pick_a;
  logic [DW-1:0] pick_b;

  always_comb begin
    pick_a = '0;
    pick_b = '0;
    for (int i = 0; i < int'(N_SHD); i++)
      if (off == OW'(i)) pick_a = shd_a[i*DW +: DW];
    for (int i = 0; i < int'(N_LOCAL); i++)
      if (off == OW'(i)) pick_b = shd_b[i*DW +: DW];
  end

  always_comb begin
    unique case (kind)
      KIND_CHMASK:  rd_val = DW'(chmask);
      KIND_XFER:    rd_val = DW'(xfer_q);
      KIND_SHD_LOC: rd_val = (chmask == 2'b10) ? pick_b : pick_a;
      KIND_SHD_GLB: rd_val = pick_a;
      default:      rd_val = '0;
    endcase
  end
endmodule

// File: rtl/cfg_dual_regfile.sv
module cfg_dual_regfile
  import cfg_regfile_pkg::*;
#(
  parameter int unsigned AW        = 8,
  parameter int unsigned DW        = 8,
  parameter int unsigned SHD_BASE  = 8,
  parameter int unsigned N_SHD     = 17,
  parameter int unsigned N_LOCAL   = 8,
  parameter int unsigned MASK_ADDR = 5,
  parameter int unsigned XFER_ADDR = 255
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [AW-1:0]       addr,
  input  logic [DW-1:0]       wr_data,
  output logic [DW-1:0]       rd_data,
  output logic                rd_valid,
  output logic [N_SHD*DW-1:0] act_a,
  output logic [N_SHD*DW-1:0] act_b
);
  localparam int unsigned OW = $clog2(N_SHD);
  localparam logic [1:0]  MASK_RST = 2'b11;

  reg_kind_e             kind;
  logic [OW-1:0]         off;
  logic [1:0]            chmask_q;
  logic                  xfer_q;
  logic                  we_a;
  logic                  we_b;
  logic [N_SHD*DW-1:0]   shd_a;
  logic [N_SHD*DW-1:0]   act_a_raw;
  logic [N_LOCAL*DW-1:0] shd_b;
  logic [N_LOCAL*DW-1:0] act_b_raw;
  logic [DW-1:0]         rd_val;

  cfg_addr_decode #(
    .AW(AW), .SHD_BASE(SHD_BASE), .N_SHD(N_SHD), .N_LOCAL(N_LOCAL),
    .MASK_ADDR(MASK_ADDR), .XFER_ADDR(XFER_ADDR), .OW(OW)
  ) dec_i (
    .addr(addr), .kind(kind), .off(off)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      chmask_q <= MASK_RST;
    else if (wr_en && kind == KIND_CHMASK)
      chmask_q <= wr_data[1:0];
  end

  // command bit lives for one cycle, then clears itself
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      xfer_q <= 1'b0;
    else
      xfer_q <= wr_en && kind == KIND_XFER && wr_data[0];
  end

  always_comb begin
    we_a = wr_en && (kind == KIND_SHD_GLB ||
                     (kind == KIND_SHD_LOC && chmask_q[0]));
    we_b = wr_en && kind == KIND_SHD_LOC && chmask_q[1];
  end

  cfg_shadow_bank #(.N_REG(N_SHD), .DW(DW), .OW(OW)) bank_a_i (
    .clk(clk), .rst_n(rst_n), .wr_en(we_a), .wr_off(off),
    .wr_data(wr_data), .xfer(xfer_q), .shd_flat(shd_a), .act_flat(act_a_raw)
  );

  cfg_shadow_bank #(.N_REG(N_LOCAL), .DW(DW), .OW(OW)) bank_b_i (
    .clk(clk), .rst_n(rst_n), .wr_en(we_b), .wr_off(off),
    .wr_data(wr_data), .xfer(xfer_q), .shd_flat(shd_b), .act_flat(act_b_raw)
  );

  assign act_a = act_a_raw;
  for (genvar i = 0; i < N_SHD; i++) begin : g_actb
    if (i < N_LOCAL) begin : g_loc
      assign act_b[i*DW +: DW] = act_b_raw[i*DW +: DW];
    end else begin : g_glb
      assign act_b[i*DW +: DW] = act_a_raw[i*DW +: DW];
    end
  end

  cfg_read_mux #(.DW(DW), .N_SHD(N_SHD), .N_LOCAL(N_LOCAL), .OW(OW)) rmux_i (
    .kind(kind), .off(off), .chmask(chmask_q), .xfer_q(xfer_q),
    .shd_a(shd_a), .shd_b(shd_b), .rd_val(rd_val)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= rd_val;
    end
  end
endmodule

// File: rtl/cfg_dual_regfile_chk.sv
module cfg_dual_regfile_chk #(
  parameter int unsigned AW        = 8,
  parameter int unsigned DW        = 8,
  parameter int unsigned SHD_BASE  = 8,
  parameter int unsigned N_SHD     = 17,
  parameter int unsigned MASK_ADDR = 5,
  parameter int unsigned XFER_ADDR = 255
) (
  input logic                clk,
  input logic                rst_n,
  input logic                wr_en,
  input logic                rd_en,
  input logic [AW-1:0]       addr,
  input logic [DW-1:0]       wr_data,
  input logic [DW-1:0]       rd_data,
  input logic                rd_valid,
  input logic [N_SHD*DW-1:0] act_a,
  input logic [N_SHD*DW-1:0] act_b
);
  logic go_cmd;
  logic unmapped;
  assign go_cmd = wr_en && addr == AW'(XFER_ADDR) && wr_data[0];
  assign unmapped = !(addr == AW'(MASK_ADDR) || addr == AW'(XFER_ADDR) ||
                      (int'(addr) >= int'(SHD_BASE) &&
                       int'(addr) < int'(SHD_BASE + N_SHD)));

  // R3
  act_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(go_cmd, 2) |-> ($stable(act_a) && $stable(act_b)));

  // R11
  rd_valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);

  // R11
  rd_valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid);

  // R10
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && unmapped) |=> rd_data == '0);

  // R2
  mask_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == AW'(MASK_ADDR)) |=> rd_data[DW-1:2] == '0);

  // R5
  go_self_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == AW'(XFER_ADDR) && !$past(go_cmd)) |=> rd_data == '0);
endmodule

bind cfg_dual_regfile cfg_dual_regfile_chk #(
  .AW(AW), .DW(DW), .SHD_BASE(SHD_BASE), .N_SHD(N_SHD),
  .MASK_ADDR(MASK_ADDR), .XFER_ADDR(XFER_ADDR)
) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wr_data(wr_data), .rd_data(rd_data), .rd_valid(rd_valid),
  .act_a(act_a), .act_b(act_b)
);

// File: tb/cfg_dual_regfile_tb.sv
module cfg_dual_regfile_tb_top;
  localparam int NS = 17;
  localparam int NL = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic          rd_en = 1'b0;
  logic [7:0]    addr = '0;
  logic [7:0]    wr_data = '0;
  logic [7:0]    rd_data;
  logic          rd_valid;
  logic [NS*8-1:0] act_a;
  logic [NS*8-1:0] act_b;

  int total = 0;
  int bad = 0;

  logic [7:0] m_shd_a [NS];
  logic [7:0] m_shd_b [NL];
  logic [7:0] m_act_a [NS];
  logic [7:0] m_act_b [NL];
  logic [1:0] m_mask;

  always #4 clk = ~clk;

  cfg_dual_regfile dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .rd_valid(rd_valid),
    .act_a(act_a), .act_b(act_b)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  function automatic logic [7:0] exp_read(input logic [7:0] a);
    if (a == 8'h05) return {6'b0, m_mask};
    if (a == 8'hFF) return 8'h00;
    if (a >= 8'h08 && a <= 8'h0F)
      return (m_mask == 2'b10) ? m_shd_b[a - 8'h08] : m_shd_a[a - 8'h08];
    if (a >= 8'h10 && a <= 8'h18) return m_shd_a[a - 8'h08];
    return 8'h00;
  endfunction

  function automatic string tag_of(input logic [7:0] a);
    if (a == 8'h05) return "R2";
    if (a == 8'hFF) return "R5";
    if (a >= 8'h08 && a <= 8'h0F) return "R7";
    if (a >= 8'h10 && a <= 8'h18) return "R8";
    return "R10";
  endfunction

  task automatic model_write(input logic [7:0] a, input logic [7:0] d);
    if (a == 8'h05) m_mask = d[1:0];
    else if (a >= 8'h08 && a <= 8'h0F) begin
      if (m_mask[0]) m_shd_a[a - 8'h08] = d;
      if (m_mask[1]) m_shd_b[a - 8'h08] = d;
    end else if (a >= 8'h10 && a <= 8'h18) m_shd_a[a - 8'h08] = d;
  endtask

  task automatic check_act(input string req);
    bit ok = 1'b1;
    int fa = 0;
    int fe = 0;
    for (int i = 0; i < NS; i++) begin
      logic [7:0] eb;
      eb = (i < NL) ? m_act_b[i] : m_act_a[i];
      if (act_a[i*8 +: 8] !== m_act_a[i]) begin
        ok = 1'b0; fa = act_a[i*8 +: 8]; fe = m_act_a[i];
      end
      if (act_b[i*8 +: 8] !== eb) begin
        ok = 1'b0; fa = act_b[i*8 +: 8]; fe = eb;
      end
    end
    chk(ok, req, fa, fe);
  endtask

  task automatic do_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(posedge clk);
    model_write(a, d);
    @(negedge clk);
    wr_en = 1'b0;
    check_act("R3");
  endtask

  task automatic do_read(input logic [7:0] a, input string req);
    logic [7:0] e;
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    e = exp_read(a);
    @(posedge clk);
    @(negedge clk);
    rd_en = 1'b0;
    chk(rd_valid === 1'b1, "R11", int'(rd_valid), 1);
    chk(rd_data === e, req, int'(rd_data), int'(e));
  endtask

  task automatic do_xfer();
    @(negedge clk);
    wr_en = 1'b1; addr = 8'hFF; wr_data = 8'h01;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
    check_act("R4");
    for (int i = 0; i < NS; i++) m_act_a[i] = m_shd_a[i];
    for (int i = 0; i < NL; i++) m_act_b[i] = m_shd_b[i];
    @(posedge clk);
    @(negedge clk);
    check_act("R4");
  endtask

  initial begin
    #(8 * 150000);
    chk(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < NS; i++) begin m_shd_a[i] = 8'(8'h40 + i); m_act_a[i] = 8'(8'h40 + i); end
    for (int i = 0; i < NL; i++) begin m_shd_b[i] = 8'(8'h40 + i); m_act_b[i] = 8'(8'h40 + i); end
    m_mask = 2'b11;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(rd_valid === 1'b0, "R11", int'(rd_valid), 0);
    check_act("R1");
    do_read(8'h05, "R1");
    do_read(8'hFF, "R1");
    do_read(8'h0C, "R1");

    // R2 mask keeps bits 1:0 only
    do_write(8'h05, 8'hFE);
    do_read(8'h05, "R2");

    // R6 / R7 write steering and read selection
    do_write(8'h05, 8'h01); do_write(8'h08, 8'hA1);
    do_write(8'h05, 8'h02); do_write(8'h08, 8'hB2);
    do_read(8'h08, "R7");
    do_write(8'h05, 8'h03); do_write(8'h09, 8'hC3);
    do_read(8'h08, "R7");
    do_write(8'h05, 8'h02); do_read(8'h09, "R6");
    do_write(8'h05, 8'h00); do_write(8'h0A, 8'hD4);
    do_read(8'h0A, "R6");
    do_read(8'h08, "R7");
    do_write(8'h05, 8'h02); do_read(8'h0A, "R6");

    // R8 global ignores mask
    do_write(8'h05, 8'h00); do_write(8'h10, 8'h5E);
    do_write(8'h05, 8'h02); do_read(8'h10, "R8");
    do_write(8'h05, 8'h01); do_write(8'h18, 8'h77);
    do_write(8'h05, 8'h02); do_read(8'h18, "R8");

    // R9 shadow read before transfer
    do_write(8'h05, 8'h01); do_write(8'h11, 8'h99);
    do_read(8'h11, "R9");

    // R4 / R5 transfer
    do_xfer();
    do_read(8'hFF, "R5");
    do_read(8'h11, "R9");

    // R10 unmapped
    do_write(8'h30, 8'hFF); do_write(8'h07, 8'h3C);
    do_read(8'h30, "R10"); do_read(8'h07, "R10"); do_read(8'h19, "R10");
    do_xfer();

    // random mix
    for (int n = 0; n < 500; n++) begin
      int sel;
      int op;
      logic [7:0] a;
      sel = int'($urandom % 20);
      op  = int'($urandom % 8);
      if (sel < 17) a = 8'(8'h08 + sel);
      else if (sel == 17) a = 8'h05;
      else if (sel == 18) a = 8'(8'h19 + ($urandom % 8'hE0));
      else a = 8'hFF;
      if (a == 8'hFF && op < 2) do_xfer();
      else if (a == 8'hFF) do_read(a, "R5");
      else if (op < 4) do_write(a, 8'($urandom));
      else do_read(a, tag_of(a));
    end
    do_xfer();
    @(negedge clk);
    chk(rd_valid === 1'b0, "R11", int'(rd_valid), 0);
    finish_run();
  end
endmodule